// File: doc/BRIEF.md
# Principal Component Projection Unit

This block forms the principal-component matrix of a data set. Every data vector is projected onto every eigenvector. For vector i and component j, the unit reads eigenvector column j and the deviation row of vector i, one element pair per cycle. It feeds the pair through a registered subtract, multiply and accumulate path and writes the finished dot product to a result buffer, tagged with (i, j).

The deviation row comes from one of two sources. It can be read as already stored, left over from an earlier covariance pass. It can also be formed on the fly by subtracting the mean vector from the raw data. The mode input picks the source. The number of dimensions m and the number of vectors n are supplied at run time. A job is launched with a start pulse and ends with a one-cycle done pulse. All three buffers are read through simple synchronous ports: the address goes out with an enable, and the data comes back on the next cycle.

Top module: `pcp_project_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, busy, done, res_we and all three read enables are low.
- R2: With dev_mode = 0, result (i, j) equals the exact signed sum over k of eig[k][j] × dat[i][k]. The data port supplies stored deviations, and each dot product is independent of the one before it.
- R3: With dev_mode = 1, result (i, j) equals the exact signed sum over k of eig[k][j] × (dat[i][k] − mean[k]). The difference is formed at DW+1 bits.
- R4: A job writes exactly m × n results in order, with i (vector) as the outer loop and j (component) as the inner loop. Each write carries res_row = i and res_col = j.
- R5: One operand pair is read per cycle, with dat at (row i, col k), eig at (row k, col j) and mean at index k, and k is the innermost loop. Consecutive result writes of a job are therefore exactly m cycles apart.
- R6: Count the edge that samples start as edge 1. The first result write is visible after edge m + 4, and done is visible after edge n·m² + 5.
- R7: done is a single-cycle pulse. It is raised only after the final result write, and busy is low while done is high.
- R8: A start with m = 0 or n = 0 issues no reads and no writes, and done is visible after edge 1.
- R9: start, dev_mode, m_dim and n_vec are sampled only when the unit is idle. Changing them while busy alters neither the results nor their count.
- R10: Full-scale operands with m = MMAX give exact results. The DW+1-bit deviation is as large as 2^DW − 1 in magnitude, and the eigenvector entry is the most negative value. The accumulator is 2·DW + 1 + ceil(log2(MMAX+1)) bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a job; sampled only when idle |
| dev_mode | input | 1 | 0: data port holds deviations; 1: subtract mean from data |
| m_dim | input | MW | Number of dimensions, 0..MMAX |
| n_vec | input | NW | Number of vectors, 0..NMAX |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse after the last write |
| eig_rd_en | output | 1 | Eigenvector buffer read enable |
| eig_rd_row | output | KW | Eigenvector row (dimension k) |
| eig_rd_col | output | KW | Eigenvector column (component j) |
| eig_rd_data | input | DW | Signed eigenvector element, one cycle after enable |
| dat_rd_en | output | 1 | Data buffer read enable |
| dat_rd_row | output | IW | Data row (vector i) |
| dat_rd_col | output | KW | Data column (dimension k) |
| dat_rd_data | input | DW | Signed data or deviation element, one cycle after enable |
| mean_rd_en | output | 1 | Mean buffer read enable |
| mean_rd_idx | output | KW | Mean index (dimension k) |
| mean_rd_data | input | DW | Signed mean element, one cycle after enable |
| res_we | output | 1 | Result write strobe |
| res_row | output | IW | Result vector index i |
| res_col | output | KW | Result component index j |
| res_data | output | ACCW | Signed projection value |

## Verification
The embedded properties rely on three conditions. Every buffer returns its element exactly one cycle after the enable. m_dim never exceeds MMAX and n_vec never exceeds NMAX, so the index and term-count checks hold. No zero-size start arrives in the same cycle as a done pulse. The bench meets these conditions by modelling each buffer as a registered array that answers one cycle after the enable. It draws m from 1..MMAX and n from 1..NMAX, gives zero sizes only in directed jobs, and launches each job only after the previous done has been seen and a few quiet cycles have passed.

// File: rtl/pcp_pkg.sv
package pcp_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RUN   = 2'd1,
    PH_DRAIN = 2'd2
  } phase_t;

  // Width of an index that addresses 'depth' entries (at least one bit).
  function automatic int idx_width(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  // Accumulator width: (DW+1)-bit deviation times DW-bit coefficient,
  // summed over up to mmax terms without overflow.
  function automatic int sum_width(input int dw, input int mmax);
    return 2 * dw + 1 + $clog2(mmax + 1);
  endfunction

endpackage

// File: rtl/pcp_seq.sv
module pcp_seq #(
  parameter int MW = 4,
  parameter int NW = 5,
  parameter int KW = 3,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [MW-1:0] m_cfg,
  input  logic [NW-1:0] n_cfg,
  output logic          issue,
  output logic [IW-1:0] pos_i,
  output logic [KW-1:0] pos_j,
  output logic [KW-1:0] pos_k,
  output logic          first_k,
  output logic          last_k,
  output logic          last_all
);

  logic run_q;
  logic last_j;
  logic last_i;

  assign issue    = run_q;
  assign first_k  = (pos_k == '0);
  assign last_k   = (int'(pos_k) + 1) == int'(m_cfg);
  assign last_j   = (int'(pos_j) + 1) == int'(m_cfg);
  assign last_i   = (int'(pos_i) + 1) == int'(n_cfg);
  assign last_all = last_k && last_j && last_i;

  // k innermost, then component j, then vector i
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pos_i <= '0;
      pos_j <= '0;
      pos_k <= '0;
    end else if (launch) begin
      run_q <= 1'b1;
      pos_i <= '0;
      pos_j <= '0;
      pos_k <= '0;
    end else if (run_q) begin
      if (last_k) begin
        pos_k <= '0;
        if (last_j) begin
          pos_j <= '0;
          if (last_i) begin
            pos_i <= '0;
            run_q <= 1'b0;
          end else begin
            pos_i <= pos_i + IW'(1);
          end
        end else begin
          pos_j <= pos_j + KW'(1);
        end
      end else begin
        pos_k <= pos_k + KW'(1);
      end
    end
  end

  // R5
  k_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (int'(pos_k) < int'(m_cfg)) && (int'(pos_j) < int'(m_cfg)));

  // R5
  k_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !last_k |=> issue && (int'(pos_k) == int'($past(pos_k)) + 1));

endmodule

// File: rtl/pcp_ctrl.sv
module pcp_ctrl
  import pcp_pkg::*;
#(
  parameter int MW = 4,
  parameter int NW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode_in,
  input  logic [MW-1:0] m_in,
  input  logic [NW-1:0] n_in,
  input  logic          last_issue,
  input  logic          final_write,
  output logic          launch,
  output logic          busy,
  output logic          done,
  output logic          mode_cfg,
  output logic [MW-1:0] m_cfg,
  output logic [NW-1:0] n_cfg
);

  phase_t ph;
  logic   zero_job;
  logic   accept;
  logic   done_r;

  assign zero_job = (m_in == '0) || (n_in == '0);
  assign accept   = (ph == PH_IDLE) && start;
  assign launch   = accept && !zero_job;
  assign busy     = (ph != PH_IDLE);
  assign done     = done_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      done_r   <= 1'b0;
      mode_cfg <= 1'b0;
      m_cfg    <= '0;
      n_cfg    <= '0;
    end else begin
      done_r <= 1'b0;
      unique case (ph)
        PH_IDLE: begin
          if (accept) begin
            mode_cfg <= mode_in;
            m_cfg    <= m_in;
            n_cfg    <= n_in;
            if (zero_job) done_r <= 1'b1;
            else          ph     <= PH_RUN;
          end
        end
        PH_RUN: begin
          if (last_issue) ph <= PH_DRAIN;
        end
        PH_DRAIN: begin
          if (final_write) begin
            ph     <= PH_IDLE;
            done_r <= 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R8
  zero_job_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && zero_job |=> done && !busy);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(m_cfg) && $stable(n_cfg) && $stable(mode_cfg));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: rtl/pcp_mac.sv
module pcp_mac #(
  parameter int DW   = 16,
  parameter int MMAX = 8,
  parameter int IW   = 4,
  parameter int KW   = 3,
  parameter int ACCW = 37
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sub_en,
  input  logic                   issue,
  input  logic                   first_k,
  input  logic                   last_k,
  input  logic                   last_all,
  input  logic [IW-1:0]          pos_i,
  input  logic [KW-1:0]          pos_j,
  input  logic signed [DW-1:0]   x_in,
  input  logic signed [DW-1:0]   mu_in,
  input  logic signed [DW-1:0]   s_in,
  output logic                   wr_v,
  output logic                   wr_fin,
  output logic [IW-1:0]          wr_i,
  output logic [KW-1:0]          wr_j,
  output logic signed [ACCW-1:0] wr_sum
);

  localparam int DEVW  = DW + 1;
  localparam int PRDW  = DEVW + DW;
  localparam int TGW   = 3 + IW + KW;
  localparam int DEPTH = 3;
  localparam int TW    = $clog2(MMAX + 1) + 1;

  // Deviation: bypass or subtract, at one bit wider than the data.
  function automatic logic signed [DEVW-1:0] form_dev(
    input logic sub, input logic signed [DW-1:0] x, input logic signed [DW-1:0] mu);
    if (sub) form_dev = DEVW'(x) - DEVW'(mu);
    else     form_dev = DEVW'(x);
  endfunction

  function automatic logic signed [PRDW-1:0] form_prod(
    input logic signed [DEVW-1:0] d, input logic signed [DW-1:0] s);
    form_prod = PRDW'(d) * PRDW'(s);
  endfunction

  // Tag travels alongside the operands: {first, last, fin, i, j}
  logic [TGW-1:0] tag_q [1:DEPTH];
  logic           vld_q [1:DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 1; s <= DEPTH; s++) begin
        vld_q[s] <= 1'b0;
        tag_q[s] <= '0;
      end
    end else begin
      vld_q[1] <= issue;
      tag_q[1] <= {first_k, last_k, last_all, pos_i, pos_j};
      for (int s = 2; s <= DEPTH; s++) begin
        vld_q[s] <= vld_q[s-1];
        tag_q[s] <= tag_q[s-1];
      end
    end
  end

  logic          s3_first, s3_last, s3_fin;
  logic [IW-1:0] s3_i;
  logic [KW-1:0] s3_j;
  assign {s3_first, s3_last, s3_fin, s3_i, s3_j} = tag_q[DEPTH];

  // Stage 1 -> 2: subtract (or bypass)
  logic signed [DEVW-1:0] dev_w;
  logic signed [DEVW-1:0] dev_r;
  logic signed [DW-1:0]   eig_r;
  assign dev_w = form_dev(sub_en, x_in, mu_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_r <= '0;
      eig_r <= '0;
    end else if (vld_q[1]) begin
      dev_r <= dev_w;
      eig_r <= s_in;
    end
  end

  // Stage 2 -> 3: multiply
  logic signed [PRDW-1:0] prod_w;
  logic signed [PRDW-1:0] prod_r;
  assign prod_w = form_prod(dev_r, eig_r);

  always_ff @(posedge clk) begin
    if (!rst_n)        prod_r <= '0;
    else if (vld_q[2]) prod_r <= prod_w;
  end

  // Stage 3: accumulate, cleared by the first term of each dot product
  logic signed [ACCW-1:0] acc_r;
  logic signed [ACCW-1:0] acc_next;
  logic                   close_w;
  logic [TW-1:0]          terms;

  assign acc_next = s3_first ? ACCW'(prod_r) : acc_r + ACCW'(prod_r);
  assign close_w  = vld_q[DEPTH] && s3_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_r  <= '0;
      terms  <= '0;
      wr_v   <= 1'b0;
      wr_fin <= 1'b0;
      wr_i   <= '0;
      wr_j   <= '0;
    end else begin
      wr_v   <= close_w;
      wr_fin <= close_w && s3_fin;
      if (vld_q[DEPTH]) begin
        acc_r <= acc_next;
        terms <= s3_first ? TW'(1) : terms + TW'(1);
      end
      if (close_w) begin
        wr_i <= s3_i;
        wr_j <= s3_j;
      end
    end
  end

  assign wr_sum = acc_r;

  // R10
  sum_terms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_v |-> (terms != '0) && (int'(terms) <= MMAX));

  // R2
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q[DEPTH] |=> $stable(acc_r));

endmodule

// File: rtl/pcp_project_unit.sv
module pcp_project_unit #(
  parameter int DW   = 16,
  parameter int MMAX = 8,
  parameter int NMAX = 16,
  parameter int KW   = pcp_pkg::idx_width(MMAX),
  parameter int IW   = pcp_pkg::idx_width(NMAX),
  parameter int MW   = $clog2(MMAX + 1),
  parameter int NW   = $clog2(NMAX + 1),
  parameter int ACCW = pcp_pkg::sum_width(DW, MMAX)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   dev_mode,
  input  logic [MW-1:0]          m_dim,
  input  logic [NW-1:0]          n_vec,
  output logic                   busy,
  output logic                   done,
  output logic                   eig_rd_en,
  output logic [KW-1:0]          eig_rd_row,
  output logic [KW-1:0]          eig_rd_col,
  input  logic signed [DW-1:0]   eig_rd_data,
  output logic                   dat_rd_en,
  output logic [IW-1:0]          dat_rd_row,
  output logic [KW-1:0]          dat_rd_col,
  input  logic signed [DW-1:0]   dat_rd_data,
  output logic                   mean_rd_en,
  output logic [KW-1:0]          mean_rd_idx,
  input  logic signed [DW-1:0]   mean_rd_data,
  output logic                   res_we,
  output logic [IW-1:0]          res_row,
  output logic [KW-1:0]          res_col,
  output logic signed [ACCW-1:0] res_data
);

  logic          launch;
  logic          mode_cfg;
  logic [MW-1:0] m_cfg;
  logic [NW-1:0] n_cfg;
  logic          issue;
  logic [IW-1:0] pos_i;
  logic [KW-1:0] pos_j;
  logic [KW-1:0] pos_k;
  logic          first_k, last_k, last_all;
  logic          wr_fin;
  logic          last_issue;
  logic          final_write;

  assign last_issue  = issue && last_all;
  assign final_write = res_we && wr_fin;

  pcp_ctrl #(.MW(MW), .NW(NW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode_in    (dev_mode),
    .m_in       (m_dim),
    .n_in       (n_vec),
    .last_issue (last_issue),
    .final_write(final_write),
    .launch     (launch),
    .busy       (busy),
    .done       (done),
    .mode_cfg   (mode_cfg),
    .m_cfg      (m_cfg),
    .n_cfg      (n_cfg)
  );

  pcp_seq #(.MW(MW), .NW(NW), .KW(KW), .IW(IW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (launch),
    .m_cfg   (m_cfg),
    .n_cfg   (n_cfg),
    .issue   (issue),
    .pos_i   (pos_i),
    .pos_j   (pos_j),
    .pos_k   (pos_k),
    .first_k (first_k),
    .last_k  (last_k),
    .last_all(last_all)
  );

  assign dat_rd_en   = issue;
  assign dat_rd_row  = pos_i;
  assign dat_rd_col  = pos_k;
  assign eig_rd_en   = issue;
  assign eig_rd_row  = pos_k;
  assign eig_rd_col  = pos_j;
  assign mean_rd_en  = issue;
  assign mean_rd_idx = pos_k;

  pcp_mac #(.DW(DW), .MMAX(MMAX), .IW(IW), .KW(KW), .ACCW(ACCW)) u_mac (
    .clk     (clk),
    .rst_n   (rst_n),
    .sub_en  (mode_cfg),
    .issue   (issue),
    .first_k (first_k),
    .last_k  (last_k),
    .last_all(last_all),
    .pos_i   (pos_i),
    .pos_j   (pos_j),
    .x_in    (dat_rd_data),
    .mu_in   (mean_rd_data),
    .s_in    (eig_rd_data),
    .wr_v    (res_we),
    .wr_fin  (wr_fin),
    .wr_i    (res_row),
    .wr_j    (res_col),
    .wr_sum  (res_data)
  );

  // R4
  res_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> (int'(res_row) < int'(n_cfg)) && (int'(res_col) < int'(m_cfg)));

  // R5
  write_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_we && (int'(m_cfg) > 1) |=> !res_we);

  // R5
  rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_rd_en |-> busy);

  // R7
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && (m_cfg != '0) && (n_cfg != '0) |-> $past(res_we));

endmodule

// File: tb/pcp_project_unit_test.sv
`timescale 1ns/1ps
module pcp_project_unit_test;

  localparam int DW   = 16;
  localparam int MMAX = 8;
  localparam int NMAX = 16;
  localparam int KW   = pcp_pkg::idx_width(MMAX);
  localparam int IW   = pcp_pkg::idx_width(NMAX);
  localparam int MW   = $clog2(MMAX + 1);
  localparam int NW   = $clog2(NMAX + 1);
  localparam int ACCW = pcp_pkg::sum_width(DW, MMAX);
  localparam logic signed [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                   rst_n, start, dev_mode;
  logic [MW-1:0]          m_dim;
  logic [NW-1:0]          n_vec;
  logic                   busy, done;
  logic                   eig_rd_en, dat_rd_en, mean_rd_en;
  logic [KW-1:0]          eig_rd_row, eig_rd_col, dat_rd_col, mean_rd_idx;
  logic [IW-1:0]          dat_rd_row;
  logic signed [DW-1:0]   eig_rd_data, dat_rd_data, mean_rd_data;
  logic                   res_we;
  logic [IW-1:0]          res_row;
  logic [KW-1:0]          res_col;
  logic signed [ACCW-1:0] res_data;

  pcp_project_unit #(.DW(DW), .MMAX(MMAX), .NMAX(NMAX)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dev_mode(dev_mode),
    .m_dim(m_dim), .n_vec(n_vec), .busy(busy), .done(done),
    .eig_rd_en(eig_rd_en), .eig_rd_row(eig_rd_row), .eig_rd_col(eig_rd_col),
    .eig_rd_data(eig_rd_data),
    .dat_rd_en(dat_rd_en), .dat_rd_row(dat_rd_row), .dat_rd_col(dat_rd_col),
    .dat_rd_data(dat_rd_data),
    .mean_rd_en(mean_rd_en), .mean_rd_idx(mean_rd_idx), .mean_rd_data(mean_rd_data),
    .res_we(res_we), .res_row(res_row), .res_col(res_col), .res_data(res_data)
  );

  // Buffers with one-cycle read latency
  logic signed [DW-1:0] dmem [NMAX][MMAX];
  logic signed [DW-1:0] emem [MMAX][MMAX];
  logic signed [DW-1:0] mmem [MMAX];

  always @(posedge clk) begin
    if (dat_rd_en)  dat_rd_data  <= dmem[dat_rd_row][dat_rd_col];
    if (eig_rd_en)  eig_rd_data  <= emem[eig_rd_row][eig_rd_col];
    if (mean_rd_en) mean_rd_data <= mmem[mean_rd_idx];
  end

  int     vectors = 0;
  int     fails   = 0;
  longint cyc     = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Job bookkeeping shared with the monitor
  longint exp_z [NMAX][MMAX];
  bit     mon_on = 1'b0;
  int     jm, jn, jmode;
  string  val_tag;
  longint c0, prev_wr, done_cyc;
  int     wr_cnt, wi, wj, rd_cnt, ri, rj, rk, done_hits;

  function automatic longint dev_of(input int md, input longint x, input longint mu);
    return (md != 0) ? (x - mu) : x;
  endfunction

  always @(negedge clk) begin
    if (mon_on) begin
      if (dat_rd_en) begin
        // R5: read addresses follow k innermost
        chk(int'(dat_rd_row) == ri && int'(dat_rd_col) == rk &&
            int'(eig_rd_row) == rk && int'(eig_rd_col) == rj &&
            int'(mean_rd_idx) == rk && eig_rd_en && mean_rd_en,
            "R5", "read address",
            longint'(dat_rd_row) * 10000 + longint'(eig_rd_col) * 100 + longint'(dat_rd_col),
            longint'(ri) * 10000 + longint'(rj) * 100 + longint'(rk));
        rd_cnt++;
        if (rk == jm - 1) begin
          rk = 0;
          if (rj == jm - 1) begin rj = 0; ri++; end
          else rj++;
        end else rk++;
      end
      if (res_we) begin
        chk(int'(res_row) == wi && int'(res_col) == wj, "R4", "write index",
            longint'(res_row) * 100 + longint'(res_col), longint'(wi) * 100 + longint'(wj));
        if (wi < NMAX && wj < MMAX)
          chk(longint'(res_data) == exp_z[wi][wj], val_tag, "result value",
              longint'(res_data), exp_z[wi][wj]);
        if (wr_cnt == 0)
          chk(cyc == c0 + jm + 4, "R6", "first write edge", cyc - c0, jm + 4);
        else
          chk(cyc - prev_wr == jm, "R5", "write spacing", cyc - prev_wr, jm);
        prev_wr = cyc;
        wr_cnt++;
        if (wj == jm - 1) begin wj = 0; wi++; end
        else wj++;
      end
      if (done) begin
        done_hits++;
        done_cyc = cyc;
        chk(!busy, "R7", "busy during done", busy, 0);
      end
    end
  end

  // kind 0: random, 1: largest positive sums, 2: largest negative sums
  task automatic run_job(input int md, input int m, input int n, input int kind,
                         input bit disturb);
    longint total;
    int     guard;
    for (int i = 0; i < NMAX; i++)
      for (int k = 0; k < MMAX; k++)
        dmem[i][k] = (kind == 1) ? SMIN : (kind == 2) ? SMAX : DW'($urandom);
    for (int k = 0; k < MMAX; k++) begin
      mmem[k] = (kind == 1) ? SMAX : (kind == 2) ? SMIN : DW'($urandom);
      for (int j = 0; j < MMAX; j++)
        emem[k][j] = (kind == 0) ? DW'($urandom) : SMIN;
    end
    for (int i = 0; i < NMAX; i++)
      for (int j = 0; j < MMAX; j++) begin
        longint acc = 0;
        for (int k = 0; k < m; k++)
          acc += longint'(emem[k][j]) * dev_of(md, longint'(dmem[i][k]), longint'(mmem[k]));
        exp_z[i][j] = acc;
      end
    jm = m; jn = n; jmode = md;
    if (kind != 0)    val_tag = "R10";
    else if (md != 0) val_tag = "R3";
    else              val_tag = "R2";
    wr_cnt = 0; wi = 0; wj = 0; rd_cnt = 0; ri = 0; rj = 0; rk = 0;
    done_hits = 0; done_cyc = -1; prev_wr = 0;
    total = longint'(n) * m * m;
    mon_on = 1'b1;
    @(negedge clk);
    c0 = cyc;
    start = 1'b1; dev_mode = md[0]; m_dim = MW'(m); n_vec = NW'(n);
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      for (int t = 0; t < 6; t++) begin
        start = 1'b1;
        dev_mode = ~dev_mode;
        m_dim = MW'($urandom_range(0, MMAX));
        n_vec = NW'($urandom_range(0, NMAX));
        @(negedge clk);
      end
      start = 1'b0;
    end
    guard = 0;
    while (done_hits == 0 && guard < int'(total) + 40) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    mon_on = 1'b0;
    chk(done_hits == 1, "R7", "done pulses", done_hits, 1);
    chk(!busy, "R7", "busy after done", busy, 0);
    if (m == 0 || n == 0) begin
      chk(done_cyc == c0 + 1, "R8", "zero-size done edge", done_cyc - c0, 1);
      chk(wr_cnt == 0 && rd_cnt == 0, "R8", "zero-size traffic", wr_cnt + rd_cnt, 0);
    end else begin
      chk(done_cyc == c0 + total + 5, "R6", "done edge", done_cyc - c0, total + 5);
      chk(rd_cnt == int'(total), "R5", "read count", rd_cnt, total);
      if (disturb) chk(wr_cnt == m * n, "R9", "write count under disturbance", wr_cnt, m * n);
      else         chk(wr_cnt == m * n, "R4", "write count", wr_cnt, m * n);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog: actual=%0d expected=%0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst_n = 1'b0; start = 1'b0; dev_mode = 1'b0; m_dim = '0; n_vec = '0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk(!busy && !done && !res_we && !dat_rd_en && !eig_rd_en && !mean_rd_en,
        "R1", "outputs in reset", {busy, done, res_we, dat_rd_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !res_we && !dat_rd_en && !eig_rd_en && !mean_rd_en,
        "R1", "outputs after reset", {busy, done, res_we, dat_rd_en}, 0);

    run_job(0, 3, 4, 0, 1'b0);      // R2 stored deviations
    run_job(1, 5, 3, 0, 1'b0);      // R3 subtract mean
    run_job(1, MMAX, NMAX, 1, 1'b0);// R10 full scale positive
    run_job(1, MMAX, 2, 2, 1'b0);   // R10 full scale negative
    run_job(0, MMAX, 3, 1, 1'b0);   // R10 bypass extremes
    run_job(1, 1, 5, 0, 1'b0);      // single dimension, writes every cycle
    run_job(0, 2, 1, 0, 1'b0);      // single vector
    run_job(1, 0, 3, 0, 1'b0);      // R8 m = 0
    run_job(0, 4, 0, 0, 1'b0);      // R8 n = 0
    run_job(0, 4, 6, 0, 1'b1);      // R9 inputs toggled while busy
    run_job(1, 3, 2, 0, 1'b0);      // back-to-back after disturbance
    for (int r = 0; r < 6; r++)
      run_job(int'($urandom_range(0, 1)), int'($urandom_range(1, MMAX)),
              int'($urandom_range(1, NMAX)), 0, 1'b0);

    summary();
    $finish;
  end

endmodule